// File: doc/BRIEF.md
# Custom Instruction Data Port

This block sits beside a processor core on its custom-instruction interface. It moves data between the core and one local storage register. The same register also drives an external output, and the block can read an external input. There are two paths. The first returns the stored value combinationally, with no stall and no change to any state, so the core may issue it speculatively and later discard it. The second is a start/done handshake for operations that change state or that must wait. It covers a one-cycle write, a one-cycle read of the stored value, and a read that waits until the external input reports valid data.

A small model of the core's result stage is part of the block. It raises a stall while a handshaked operation is in flight. It then registers the completed result into a write-back register. A bench can therefore measure the cost of each operation in cycles: 1 for the combinational read, 2 for either one-cycle operation, and latency plus 1 for the waiting read.

A write commits at the end of its done cycle. A combinational read made during that cycle still sees the old value. A one-cycle handshaked read issued afterwards sees the new one.

Top module: `ci_data_port`

## Requirements
- R1: After a synchronous reset the stored value, `ext_out`, `done`, `stall` and `wb_valid` are all zero.
- R2: With `op`=00 and `start` high in cycle T, `comb_result` equals the stored value in cycle T and `stall` stays low. `wb_valid` is high in T+1 with that value, so the cost is 1 cycle, and neither the stored value nor `ext_out` changes.
- R3: With `op`=01 issued in cycle T, `stall` is high only in T. `done` is high in T+1 with `result` equal to the issued `dataa`. The stored value and `ext_out` take `dataa` at the end of T+1, and `wb_valid` is high in T+2, so the cost is 2 cycles.
- R4: With `op`=11 issued in cycle T, `done` is high in T+1 with `result` equal to the stored value, and the write-back follows in T+2, so the cost is 2 cycles.
- R5: With `op`=10 issued in cycle T, `done` stays low and `stall` stays high until the first cycle D>T in which `ext_in_valid` is high. In cycle D, `done` is high and `result` equals `ext_in`. The write-back follows in D+1, so the cost is (D−T)+1 cycles.
- R6: A `start` that arrives while a handshaked operation is in flight is ignored. It neither restarts the operation nor changes the stored value or `ext_out`.
- R7: A combinational read in the done cycle of a write returns the value from before the write. A later `op`=11 read returns the written value.
- R8: While `clk_en` is low no state changes, `done` is held low and an in-flight operation keeps `stall` high. Progress resumes when `clk_en` returns high.
- R9: Every `done` cycle taken with `clk_en` high is followed by exactly one `wb_valid` cycle, and `wb_data` equals the `result` of that done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock enable; when low the block holds its state |
| start | input | 1 | One-cycle issue pulse |
| op | input | 2 | 00 comb read, 01 write, 10 wait-read, 11 one-cycle read |
| dataa | input | 32 | Operand for a write |
| ext_in | input | 32 | External input data |
| ext_in_valid | input | 1 | External input data is valid |
| result | output | 32 | Handshaked result, meaningful only while `done` is high |
| done | output | 1 | Handshaked operation completes this cycle |
| comb_result | output | 32 | Combinational read of the stored value |
| ext_out | output | 32 | External output register |
| stall | output | 1 | Modelled core stall request |
| wb_data | output | 32 | Registered write-back data |
| wb_valid | output | 1 | Write-back register holds a new result |

## Verification
The assertions assume that `start` is a single-cycle pulse, that `op` is stable while `start` is high, and that `rst` is held for at least one clock edge before use. Each bench task raises `start` for exactly one cycle at a falling edge and drives every input only at falling edges. The bench issues `start` during a busy period only in the task written to exercise that case. It changes `ext_in_valid` only while a waiting read is pending, so no stray valid data can satisfy a later read.

// File: rtl/ci_pkg.sv
package ci_pkg;

    typedef enum logic [1:0] {
        OP_COMB   = 2'b00,
        OP_WRITE  = 2'b01,
        OP_WAITRD = 2'b10,
        OP_SYNCRD = 2'b11
    } ci_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ONE  = 2'd1,
        ST_WAIT = 2'd2
    } ci_state_e;

    function automatic logic is_handshaked(ci_op_e o);
        return o != OP_COMB;
    endfunction

    function automatic ci_state_e first_state(ci_op_e o);
        return (o == OP_WAITRD) ? ST_WAIT : ST_ONE;
    endfunction

endpackage

// File: rtl/ci_store.sv
module ci_store #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [DATA_W-1:0] commit_data,
    output logic [DATA_W-1:0] stored,
    output logic [DATA_W-1:0] ext_out
);
    logic [DATA_W-1:0] stored_q;
    logic [DATA_W-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stored_q <= '0;
            out_q    <= '0;
        end else if (commit) begin
            stored_q <= commit_data;
            out_q    <= commit_data;
        end
    end

    assign stored  = stored_q;
    assign ext_out = out_q;

    // R2 / R6: only a commit from the engine may change the stored value
    a_r2_no_stray_write: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(stored_q) && $stable(out_q));

endmodule

// File: rtl/ci_mc_engine.sv
module ci_mc_engine
    import ci_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              start,
    input  ci_op_e            op,
    input  logic [DATA_W-1:0] dataa,
    input  logic [DATA_W-1:0] ext_in,
    input  logic              ext_in_valid,
    input  logic [DATA_W-1:0] stored,
    output logic              busy,
    output logic              issue,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              commit,
    output logic [DATA_W-1:0] commit_data
);
    ci_state_e         state_q, state_d;
    ci_op_e            op_q;
    logic [DATA_W-1:0] hold_q;

    assign busy  = state_q != ST_IDLE;
    assign issue = clk_en && start && !busy && is_handshaked(op);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (issue) state_d = first_state(op);
            ST_ONE:  if (clk_en) state_d = ST_IDLE;
            ST_WAIT: if (clk_en && ext_in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_COMB;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (issue) begin
                op_q   <= op;
                hold_q <= dataa;
            end
        end
    end

    always_comb begin
        done   = 1'b0;
        result = '0;
        if (clk_en) begin
            if (state_q == ST_ONE) begin
                done   = 1'b1;
                result = (op_q == OP_WRITE) ? hold_q : stored;
            end else if (state_q == ST_WAIT && ext_in_valid) begin
                done   = 1'b1;
                result = ext_in;
            end
        end
    end

    assign commit      = clk_en && state_q == ST_ONE && op_q == OP_WRITE;
    assign commit_data = hold_q;

    // R3 / R4: a one-cycle operation completes as soon as the clock is enabled
    a_r3_fixed_done: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ONE && clk_en) |-> done);
    // R5: no completion of a waiting read without valid input
    a_r5_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !ext_in_valid) |-> !done);
    // R6: a start while busy does not end or restart the operation
    a_r6_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !done) |=> busy && $stable(op_q) && $stable(hold_q));
    // R8: no progress while the clock enable is low
    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(state_q));

endmodule

// File: rtl/ci_cpu_stage.sv
module ci_cpu_stage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              comb_issue,
    input  logic [DATA_W-1:0] comb_data,
    input  logic              issue,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] result,
    output logic              stall,
    output logic [DATA_W-1:0] wb_data,
    output logic              wb_valid
);
    logic              wb_valid_q;
    logic [DATA_W-1:0] wb_data_q;

    assign stall = issue || (busy && !done);

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid_q <= 1'b0;
            wb_data_q  <= '0;
        end else if (clk_en) begin
            wb_valid_q <= done || comb_issue;
            wb_data_q  <= done ? result : comb_data;
        end
    end

    assign wb_valid = wb_valid_q;
    assign wb_data  = wb_data_q;

    // R2: the combinational path never stalls
    a_r2_comb_no_stall: assert property (@(posedge clk) disable iff (rst)
        comb_issue |-> !stall);
    // R9: each completion is written back in the next cycle with its result
    a_r9_wb_follows: assert property (@(posedge clk) disable iff (rst)
        (done && clk_en) |=> wb_valid && wb_data == $past(result));

endmodule

// File: rtl/ci_data_port.sv
module ci_data_port
    import ci_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] dataa,
    input  logic [DATA_W-1:0] ext_in,
    input  logic              ext_in_valid,
    output logic [DATA_W-1:0] result,
    output logic              done,
    output logic [DATA_W-1:0] comb_result,
    output logic [DATA_W-1:0] ext_out,
    output logic              stall,
    output logic [DATA_W-1:0] wb_data,
    output logic              wb_valid
);
    ci_op_e            op_e;
    logic [DATA_W-1:0] stored;
    logic              busy, issue, commit, comb_issue;
    logic [DATA_W-1:0] commit_data;

    assign op_e        = ci_op_e'(op);
    assign comb_result = stored;
    assign comb_issue  = start && !busy && op_e == OP_COMB;

    ci_store #(.DATA_W(DATA_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .commit_data (commit_data),
        .stored      (stored),
        .ext_out     (ext_out)
    );

    ci_mc_engine #(.DATA_W(DATA_W)) u_engine (
        .clk          (clk),
        .rst          (rst),
        .clk_en       (clk_en),
        .start        (start),
        .op           (op_e),
        .dataa        (dataa),
        .ext_in       (ext_in),
        .ext_in_valid (ext_in_valid),
        .stored       (stored),
        .busy         (busy),
        .issue        (issue),
        .done         (done),
        .result       (result),
        .commit       (commit),
        .commit_data  (commit_data)
    );

    ci_cpu_stage #(.DATA_W(DATA_W)) u_stage (
        .clk        (clk),
        .rst        (rst),
        .clk_en     (clk_en),
        .comb_issue (comb_issue),
        .comb_data  (stored),
        .issue      (issue),
        .busy       (busy),
        .done       (done),
        .result     (result),
        .stall      (stall),
        .wb_data    (wb_data),
        .wb_valid   (wb_valid)
    );

    // R1 / R3: outputs follow the store only through committed writes
    a_r1_out_tracks_store: assert property (@(posedge clk) disable iff (rst)
        ext_out == comb_result);

endmodule

// File: tb/tb_ci_data_port.sv
module tb_ci_data_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] dataa = '0;
    logic [31:0] ext_in = '0;
    logic        ext_in_valid = 1'b0;
    logic [31:0] result, comb_result, ext_out, wb_data;
    logic        done, stall, wb_valid;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    logic [31:0] model = '0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ci_data_port dut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .start(start), .op(op),
        .dataa(dataa), .ext_in(ext_in), .ext_in_valid(ext_in_valid),
        .result(result), .done(done), .comb_result(comb_result),
        .ext_out(ext_out), .stall(stall), .wb_data(wb_data), .wb_valid(wb_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 ext_out", ext_out, 32'h0);
        chk("R1 stored", comb_result, 32'h0);
        chk("R1 done", {31'h0, done}, 32'h0);
        chk("R1 stall", {31'h0, stall}, 32'h0);
        chk("R1 wb_valid", {31'h0, wb_valid}, 32'h0);
    endtask

    task automatic t_write(input logic [31:0] d);
        int t0;
        @(negedge clk); start = 1'b1; op = 2'b01; dataa = d; t0 = cyc; #1;
        chk("R3 stall in issue cycle", {31'h0, stall}, 32'h1);
        @(negedge clk); start = 1'b0; #1;
        chk("R3 done", {31'h0, done}, 32'h1);
        chk("R3 result", result, d);
        chk("R3 stall released", {31'h0, stall}, 32'h0);
        chk("R7 comb read old value", comb_result, model);
        step();
        chk("R3 wb_valid", {31'h0, wb_valid}, 32'h1);
        chk("R3 wb_data", wb_data, d);
        chk("R3 ext_out", ext_out, d);
        chk("R3 cost", cyc - t0, 2);
        model = d;
    endtask

    task automatic t_comb();
        int t0;
        @(negedge clk); start = 1'b1; op = 2'b00; t0 = cyc; #1;
        chk("R2 comb value", comb_result, model);
        chk("R2 no stall", {31'h0, stall}, 32'h0);
        @(negedge clk); start = 1'b0; #1;
        chk("R2 wb_data", wb_data, model);
        chk("R2 cost", cyc - t0, 1);
        chk("R2 ext_out unchanged", ext_out, model);
        step();
        chk("R9 single wb pulse", {31'h0, wb_valid}, 32'h0);
    endtask

    task automatic t_syncrd();
        int t0;
        @(negedge clk); start = 1'b1; op = 2'b11; t0 = cyc;
        @(negedge clk); start = 1'b0; #1;
        chk("R4 done", {31'h0, done}, 32'h1);
        chk("R7 sync read new value", result, model);
        step();
        chk("R4 wb_data", wb_data, model);
        chk("R4 cost", cyc - t0, 2);
    endtask

    task automatic t_wait(input int lat, input logic [31:0] v);
        int t0;
        @(negedge clk); start = 1'b1; op = 2'b10; t0 = cyc;
        for (int k = 1; k < lat; k++) begin
            @(negedge clk); start = 1'b0; #1;
            chk("R5 done held low", {31'h0, done}, 32'h0);
            chk("R5 stall held", {31'h0, stall}, 32'h1);
        end
        @(negedge clk); start = 1'b0; ext_in = v; ext_in_valid = 1'b1; #1;
        chk("R5 done on valid", {31'h0, done}, 32'h1);
        chk("R5 result", result, v);
        @(negedge clk); ext_in_valid = 1'b0; #1;
        chk("R9 wb_data", wb_data, v);
        chk("R5 cost", cyc - t0, lat + 1);
    endtask

    task automatic t_busy();
        @(negedge clk); start = 1'b1; op = 2'b10;
        @(negedge clk); start = 1'b1; op = 2'b01; dataa = 32'hBAD0BAD0; #1;
        chk("R6 still waiting", {31'h0, done}, 32'h0);
        @(negedge clk); start = 1'b0; ext_in = 32'h0000_5A5A; ext_in_valid = 1'b1; #1;
        chk("R6 original op completes", result, 32'h0000_5A5A);
        @(negedge clk); ext_in_valid = 1'b0; #1;
        chk("R6 wb", wb_data, 32'h0000_5A5A);
        step();
        chk("R6 no second done", {31'h0, done}, 32'h0);
        chk("R6 no second wb", {31'h0, wb_valid}, 32'h0);
        chk("R6 store unchanged", comb_result, model);
        chk("R6 ext_out unchanged", ext_out, model);
    endtask

    task automatic t_clken(input logic [31:0] d);
        @(negedge clk); start = 1'b1; op = 2'b01; dataa = d;
        @(negedge clk); start = 1'b0; clk_en = 1'b0; #1;
        chk("R8 done gated", {31'h0, done}, 32'h0);
        chk("R8 stall held", {31'h0, stall}, 32'h1);
        step();
        chk("R8 ext_out frozen", ext_out, model);
        chk("R8 no wb", {31'h0, wb_valid}, 32'h0);
        @(negedge clk); clk_en = 1'b1; #1;
        chk("R8 resumes", {31'h0, done}, 32'h1);
        step();
        chk("R8 ext_out updated", ext_out, d);
        chk("R9 wb after resume", wb_data, d);
        model = d;
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_comb();
        t_write(32'h1234_5678);
        t_comb();
        t_syncrd();
        t_write(32'hCAFE_0001);
        t_syncrd();
        t_wait(1, 32'hA5A5_0001);
        t_wait(4, 32'h0F0F_F0F0);
        t_busy();
        t_clken(32'h7777_0002);
        t_comb();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule